// File: doc/BRIEF.md
# Two-Wire Block Transfer Sequencer

This block turns one request (device address, register offset, byte count, direction and addressing mode) into the full sequence of byte-level commands for a two-wire serial bus. It drives a separate byte engine, which is not part of this block. The engine performs each START, byte write, byte read or STOP and reports the acknowledge bit it saw.

In standard mode the device address byte is followed by a one-byte register offset. A read then waits for a bus-free gap. It turns the bus around with a repeated START, with no STOP in between, and sends the device address with the read bit set.

In legacy mode there is no register byte. The offset itself, shifted up by one bit, forms the address byte.

Writes are cut into chunks of at most four bytes. Each chunk:
- re-addresses the device at the current offset;
- ends with STOP;
- is followed by acknowledge polling until the device has finished its internal write;
- closes with one read byte that is discarded.

Write bytes arrive on a valid/ready stream. Read bytes leave on a valid/ready stream.

Back-pressure rules:
- On the read side, `rd_valid` stays high and `rd_data` stays stable until `rd_ready` is sampled high. The next bus read is not issued until then.
- On the write side, `wr_ready` is high only while the sequencer is waiting for the next data byte. One byte is taken per handshake, and stalls on `wr_valid` simply pause the bus.

Top module: `tw_block_xfer`

## Requirements
- R1: After reset `busy`, `done`, `error`, `eng_req`, `wr_ready` and `rd_valid` are low. A `start` pulse while `busy` is high has no effect on the command sequence.
- R2: `eng_req` is raised with `eng_op`, `eng_start`, `eng_nack` and `eng_wdata` and holds them stable until the cycle `eng_done` is high.
  - `eng_op` encodings: 0 = write byte, 1 = read byte, 2 = STOP.
  - `eng_start` = 1 on a write means a (repeated) START precedes the byte.
  - `eng_nack` = 1 on a read means the master answers NACK.
- R3: In legacy mode (`legacy` = 1) the transfer opens with one START byte `{offset[6:0], rw}`, where rw = 1 for read and 0 for write. No register byte is sent.
- R4: A standard-mode read sends these commands, with no STOP anywhere in the sequence:
  - START with `{dev_addr[7:1], 0}`;
  - the offset byte;
  - a wait of at least GAP_CYCLES clocks;
  - START with `{dev_addr[7:1], 1}`.
- R5: A read issues `length` read commands, ACKing all but the last, which is NACKed, and then a STOP. The bytes appear on the read stream in bus order.
- R6: Writes go out in chunks of at most CHUNK (4) data bytes.
  - Each chunk starts with START plus addressing at the current offset.
  - The offset advances by the bytes sent.
  - Each chunk ends with STOP.
  - Exactly one stream byte is taken per data write command.
- R7: After each chunk STOP the block polls with START `{dev_addr[7:1], 1}`.
  - A NACK is followed by STOP and another attempt.
  - An ACK is followed by one read with NACK, a STOP, and then the next chunk or completion.
- R8: When POLL_MAX (100) poll attempts are NACKed, the transfer ends with `error` after the STOP of the last attempt.
- R9: A NACK on an address, register or data byte is followed by one STOP, and the transfer then ends with `error`.
- R10: A `length` of zero raises `done` in the next cycle with `error` low and issues no engine command.
- R11: `done` is a one-cycle pulse with `busy` low. `error` is valid with `done` and holds until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| legacy | input | 1 | 1 = offset carried in the address byte |
| rd | input | 1 | 1 = read, 0 = write |
| dev_addr | input | 8 | Device address, bit 0 ignored |
| offset | input | 8 | Register offset |
| length | input | LEN_W | Byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Transfer failed (valid with done) |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte accepted this cycle if valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes read byte |
| rd_data | output | 8 | Read byte |
| eng_req | output | 1 | Command pending to byte engine |
| eng_op | output | 2 | 0 write, 1 read, 2 STOP |
| eng_start | output | 1 | Precede write byte with START |
| eng_nack | output | 1 | Answer NACK on this read |
| eng_wdata | output | 8 | Byte to write |
| eng_done | input | 1 | Engine finished the command (one cycle) |
| eng_ack | input | 1 | Acknowledge seen on a write |
| eng_rdata | input | 8 | Byte read by the engine |

## Verification
A corrupted state register shows up at the engine port within one command: an out-of-place op, START flag or byte appears in the traced command list, or a STOP is missing before `done`. Errors in chunk or poll counting appear at the end of the first chunk, as a chunk that is too long, a missing re-address, or a poll loop that ends too early or too late. The final `error` and the number of stream bytes taken expose these too. A wrong gap count appears as a repeated START that comes too soon after the register byte.

// File: rtl/tw_xfer_pkg.sv
package tw_xfer_pkg;
  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_RD   = 2'd1,
    OP_STOP = 2'd2
  } tw_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_REG, S_GAP, S_DEVR, S_RDATA, S_PUSH, S_FETCH,
    S_WDATA, S_WSTOP, S_POLL, S_PSTOP, S_DISC, S_DSTOP, S_ABORT, S_FSTOP
  } tw_state_e;
endpackage

// File: rtl/tw_limit_counter.sv
module tw_limit_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tw_gap_timer.sv
module tw_gap_timer #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/tw_cmd_decode.sv
module tw_cmd_decode
  import tw_xfer_pkg::*;
(
  input  tw_state_e   state,
  input  logic        legacy,
  input  logic        rd_mode,
  input  logic        last_byte,
  input  logic [7:0]  dev,
  input  logic [7:0]  cur_off,
  input  logic [7:0]  wbyte,
  output logic        req,
  output tw_op_e      op,
  output logic        start_cond,
  output logic        nack,
  output logic [7:0]  wdata
);
  always_comb begin
    req        = 1'b0;
    op         = OP_STOP;
    start_cond = 1'b0;
    nack       = 1'b0;
    wdata      = 8'h00;
    unique case (state)
      S_ADDR: begin
        req = 1'b1; op = OP_WR; start_cond = 1'b1;
        wdata = legacy ? {cur_off[6:0], rd_mode} : {dev[7:1], 1'b0};
      end
      S_REG: begin
        req = 1'b1; op = OP_WR; wdata = cur_off;
      end
      S_DEVR, S_POLL: begin
        req = 1'b1; op = OP_WR; start_cond = 1'b1; wdata = {dev[7:1], 1'b1};
      end
      S_RDATA: begin
        req = 1'b1; op = OP_RD; nack = last_byte;
      end
      S_DISC: begin
        req = 1'b1; op = OP_RD; nack = 1'b1;
      end
      S_WDATA: begin
        req = 1'b1; op = OP_WR; wdata = wbyte;
      end
      S_WSTOP, S_PSTOP, S_DSTOP, S_ABORT, S_FSTOP: begin
        req = 1'b1; op = OP_STOP;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tw_block_xfer.sv
module tw_block_xfer
  import tw_xfer_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int CHUNK      = 4,
  parameter int POLL_MAX   = 100,
  parameter int GAP_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             legacy,
  input  logic             rd,
  input  logic [7:0]       dev_addr,
  input  logic [7:0]       offset,
  input  logic [LEN_W-1:0] length,
  output logic             busy,
  output logic             done,
  output logic             error,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             eng_req,
  output logic [1:0]       eng_op,
  output logic             eng_start,
  output logic             eng_nack,
  input  logic             eng_done,
  input  logic             eng_ack,
  output logic [7:0]       eng_wdata,
  input  logic [7:0]       eng_rdata
);
  localparam int CW = $clog2(CHUNK + 1);
  localparam int PW = $clog2(POLL_MAX + 1);

  tw_state_e        state;
  logic             legacy_q, rd_mode;
  logic [7:0]       dev_q, cur_off, wbyte, rbyte;
  logic [LEN_W-1:0] remaining;
  logic [CW-1:0]    chunk_cnt;
  logic [PW-1:0]    poll_cnt;
  logic             chunk_clr, chunk_inc, poll_clr, poll_inc, gap_load, gap_expired;
  logic             last_byte, chunk_end;
  tw_op_e           op_e;

  assign last_byte = (remaining == LEN_W'(1));
  assign chunk_end = (chunk_cnt == CW'(CHUNK - 1)) || last_byte;

  always_comb begin
    chunk_clr = (state == S_IDLE) || (state == S_DSTOP && eng_done);
    chunk_inc = (state == S_WDATA) && eng_done && eng_ack;
    poll_clr  = (state == S_WSTOP) && eng_done;
    poll_inc  = (state == S_POLL) && eng_done && !eng_ack;
    gap_load  = (state == S_REG) && eng_done && eng_ack && rd_mode;
  end

  tw_limit_counter #(.W(CW)) u_chunk (
    .clk(clk), .rst_n(rst_n), .clr(chunk_clr), .inc(chunk_inc), .cnt(chunk_cnt)
  );

  tw_limit_counter #(.W(PW)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .cnt(poll_cnt)
  );

  tw_gap_timer #(.CYC(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .expired(gap_expired)
  );

  tw_cmd_decode u_dec (
    .state(state), .legacy(legacy_q), .rd_mode(rd_mode), .last_byte(last_byte),
    .dev(dev_q), .cur_off(cur_off), .wbyte(wbyte),
    .req(eng_req), .op(op_e), .start_cond(eng_start), .nack(eng_nack),
    .wdata(eng_wdata)
  );
  assign eng_op = op_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      done      <= 1'b0;
      error     <= 1'b0;
      legacy_q  <= 1'b0;
      rd_mode   <= 1'b0;
      dev_q     <= '0;
      cur_off   <= '0;
      remaining <= '0;
      wbyte     <= '0;
      rbyte     <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          legacy_q  <= legacy;
          rd_mode   <= rd;
          dev_q     <= dev_addr;
          cur_off   <= offset;
          remaining <= length;
          error     <= 1'b0;
          if (length == '0) done  <= 1'b1;
          else              state <= S_ADDR;
        end
        S_ADDR: if (eng_done) begin
          if (!eng_ack)      state <= S_ABORT;
          else if (legacy_q) state <= rd_mode ? S_RDATA : S_FETCH;
          else               state <= S_REG;
        end
        S_REG: if (eng_done) begin
          if (!eng_ack) state <= S_ABORT;
          else          state <= rd_mode ? S_GAP : S_FETCH;
        end
        S_GAP: if (gap_expired) state <= S_DEVR;
        S_DEVR: if (eng_done) state <= eng_ack ? S_RDATA : S_ABORT;
        S_RDATA: if (eng_done) begin
          rbyte <= eng_rdata;
          state <= S_PUSH;
        end
        S_PUSH: if (rd_ready) begin
          remaining <= remaining - 1'b1;
          state     <= last_byte ? S_FSTOP : S_RDATA;
        end
        S_FETCH: if (wr_valid) begin
          wbyte <= wr_data;
          state <= S_WDATA;
        end
        S_WDATA: if (eng_done) begin
          if (!eng_ack) state <= S_ABORT;
          else begin
            remaining <= remaining - 1'b1;
            cur_off   <= cur_off + 1'b1;
            state     <= chunk_end ? S_WSTOP : S_FETCH;
          end
        end
        S_WSTOP: if (eng_done) state <= S_POLL;
        S_POLL:  if (eng_done) state <= eng_ack ? S_DISC : S_PSTOP;
        S_PSTOP: if (eng_done) begin
          if (poll_cnt == PW'(POLL_MAX)) begin
            state <= S_IDLE; done <= 1'b1; error <= 1'b1;
          end else state <= S_POLL;
        end
        S_DISC: if (eng_done) state <= S_DSTOP;
        S_DSTOP: if (eng_done) begin
          if (remaining == '0) begin
            state <= S_IDLE; done <= 1'b1;
          end else state <= S_ADDR;
        end
        S_ABORT: if (eng_done) begin
          state <= S_IDLE; done <= 1'b1; error <= 1'b1;
        end
        S_FSTOP: if (eng_done) begin
          state <= S_IDLE; done <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign wr_ready = (state == S_FETCH);
  assign rd_valid = (state == S_PUSH);
  assign rd_data  = rbyte;

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_wdata)
                              && $stable(eng_start) && $stable(eng_nack)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R5
  AST_WR_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_ready); // R6
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= PW'(POLL_MAX)); // R8
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && length == '0 |=> done && !error && !busy && !eng_req); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !eng_req); // R11
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done); // R11
endmodule

// File: tb/tb_tw_block_xfer.sv
`timescale 1ns/1ps
module tb_tw_block_xfer;
  localparam int GAP = 16;
  localparam int PMAX = 100;

  typedef struct packed {
    logic       legacy;
    logic       rd;
    logic [7:0] dev;
    logic [7:0] off;
    logic [7:0] len;
    logic [7:0] pn;
    logic [7:0] nack_at;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'hA0, 8'h10, 8'd3, 8'd0, 8'hFF},  // std read
    '{1'b1, 1'b1, 8'h00, 8'h05, 8'd2, 8'd0, 8'hFF},  // legacy read
    '{1'b0, 1'b0, 8'hA0, 8'h20, 8'd6, 8'd2, 8'hFF},  // std write 4+2, polls
    '{1'b1, 1'b0, 8'hA2, 8'h30, 8'd4, 8'd0, 8'hFF},  // legacy write
    '{1'b0, 1'b0, 8'h50, 8'hFE, 8'd9, 8'd1, 8'hFF},  // std write 4+4+1 wrap
    '{1'b0, 1'b1, 8'hA0, 8'h10, 8'd3, 8'd0, 8'd0},   // addr nack
    '{1'b0, 1'b1, 8'hA0, 8'h10, 8'd3, 8'd0, 8'd1},   // reg nack
    '{1'b0, 1'b0, 8'hA0, 8'h40, 8'd5, 8'd0, 8'd3},   // data nack
    '{1'b0, 1'b1, 8'hA0, 8'h10, 8'd2, 8'd0, 8'd2}    // repeated-start nack
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, legacy = 0, rd = 0;
  logic [7:0] dev_addr = 0, offset = 0, length = 0;
  logic busy, done, error;
  logic wr_valid = 0, wr_ready;
  logic [7:0] wr_data = 0;
  logic rd_valid, rd_ready = 0;
  logic [7:0] rd_data;
  logic eng_req, eng_start, eng_nack;
  logic [1:0] eng_op;
  logic [7:0] eng_wdata;
  logic eng_done = 0, eng_ack = 0;
  logic [7:0] eng_rdata = 0;

  always #2 clk = ~clk;

  tw_block_xfer #(.GAP_CYCLES(GAP), .POLL_MAX(PMAX)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .legacy(legacy), .rd(rd),
    .dev_addr(dev_addr), .offset(offset), .length(length),
    .busy(busy), .done(done), .error(error),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .eng_req(eng_req), .eng_op(eng_op), .eng_start(eng_start), .eng_nack(eng_nack),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
  );

  int checks = 0, errors = 0;
  logic [11:0] trace [0:511];
  logic [11:0] expv  [0:511];
  int t_acc [0:511];
  int t_done [0:511];
  logic [7:0] rdat [0:63];
  int tn = 0, rn = 0, widx = 0, exp_n = 0, exp_wcnt = 0, cyc = 0;
  bit exp_err = 0;
  int cfg_nack_at = -1, cfg_pn = 0, busy_left = 0, rdcount = 0, eng_cnt = 0;
  bit cfg_wtest = 0, prev_plain_wr = 0, eng_busy = 0;
  logic [7:0] rd_base = 0, wbase = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expd);
    end
  endtask

  // Bench-side byte engine, write source and read sink, all away from posedge.
  always @(negedge clk) begin
    cyc++;
    rd_ready = (cyc % 3 != 0);
    wr_valid = (cyc % 4 != 1);
    wr_data  = wbase + 8'(widx);
    if (wr_valid && wr_ready) widx++;
    if (rd_valid && rd_ready && rn < 64) begin rdat[rn] = rd_data; rn++; end
    if (!rst_n) begin
      eng_done = 0; eng_busy = 0;
    end else if (eng_done) begin
      eng_done = 0;
    end else if (eng_busy) begin
      eng_cnt--;
      if (eng_cnt == 0) begin eng_busy = 0; eng_done = 1; t_done[tn-1] = cyc; end
    end else if (eng_req && tn < 512) begin
      eng_ack = 1;
      if (eng_op == 2'd0) begin
        trace[tn] = {eng_op, eng_start, 1'b0, eng_wdata};
        if (tn == cfg_nack_at) eng_ack = 0;
        else if (eng_start && eng_wdata[0] && cfg_wtest && busy_left > 0) begin
          eng_ack = 0; busy_left--;
        end
        prev_plain_wr = !eng_start;
      end else if (eng_op == 2'd1) begin
        trace[tn] = {eng_op, 1'b0, eng_nack, 8'h00};
        eng_rdata = rd_base + 8'(rdcount); rdcount++;
        prev_plain_wr = 0;
      end else begin
        trace[tn] = {eng_op, 2'b00, 8'h00};
        if (prev_plain_wr) busy_left = cfg_pn;
        prev_plain_wr = 0;
      end
      t_acc[tn] = cyc; tn++;
      eng_busy = 1; eng_cnt = 2;
    end
  end

  function automatic logic [11:0] ent(input logic [1:0] op, input logic s,
                                      input logic n, input logic [7:0] d);
    return {op, s, n, d};
  endfunction

  task automatic epush(input logic [11:0] e, output bit nak);
    expv[exp_n] = e;
    nak = (e[11:10] == 2'd0) && (exp_n == cfg_nack_at);
    exp_n++;
  endtask

  // Expected command list derived from R3..R9.
  task automatic build(input vec_t v);
    bit nk;
    logic [7:0] o;
    int rem, n, p, pos;
    exp_n = 0; exp_err = 0; exp_wcnt = 0; nk = 0;
    if (v.len == 0) return;
    if (v.rd) begin
      epush(ent(2'd0, 1, 0, v.legacy ? {v.off[6:0], 1'b1} : {v.dev[7:1], 1'b0}), nk);
      if (!nk && !v.legacy) begin
        epush(ent(2'd0, 0, 0, v.off), nk);
        if (!nk) epush(ent(2'd0, 1, 0, {v.dev[7:1], 1'b1}), nk);
      end
      if (nk) begin epush(ent(2'd2, 0, 0, 0), nk); exp_err = 1; return; end
      for (int i = 0; i < int'(v.len); i++) epush(ent(2'd1, 0, i == int'(v.len) - 1, 0), nk);
      epush(ent(2'd2, 0, 0, 0), nk);
      return;
    end
    o = v.off; rem = v.len; pos = 0;
    while (rem > 0) begin
      epush(ent(2'd0, 1, 0, v.legacy ? {o[6:0], 1'b0} : {v.dev[7:1], 1'b0}), nk);
      if (!nk && !v.legacy) epush(ent(2'd0, 0, 0, o), nk);
      n = (rem > 4) ? 4 : rem;
      for (int k = 0; k < n && !nk; k++) begin
        epush(ent(2'd0, 0, 0, wbase + 8'(pos)), nk); pos++; exp_wcnt++;
      end
      if (nk) begin epush(ent(2'd2, 0, 0, 0), nk); exp_err = 1; return; end
      o = o + 8'(n); rem -= n;
      epush(ent(2'd2, 0, 0, 0), nk);
      p = 0;
      while (p < int'(v.pn) && p < PMAX) begin
        epush(ent(2'd0, 1, 0, {v.dev[7:1], 1'b1}), nk);
        epush(ent(2'd2, 0, 0, 0), nk);
        p++;
      end
      if (p == PMAX) begin exp_err = 1; return; end
      epush(ent(2'd0, 1, 0, {v.dev[7:1], 1'b1}), nk);
      epush(ent(2'd1, 0, 1, 0), nk);
      epush(ent(2'd2, 0, 0, 0), nk);
    end
  endtask

  task automatic run(input vec_t v, input int vi, input bit poke, input string tag);
    int k, mism, first;
    bit seen;
    @(negedge clk);
    cfg_nack_at = (v.nack_at == 8'hFF) ? -1 : int'(v.nack_at);
    cfg_pn = v.pn; cfg_wtest = !v.rd; busy_left = 0; prev_plain_wr = 0;
    rdcount = 0; rd_base = 8'h80 + 8'(vi * 8); wbase = 8'h10 + 8'(vi * 16);
    tn = 0; rn = 0; widx = 0;
    build(v);
    start = 1; legacy = v.legacy; rd = v.rd; dev_addr = v.dev;
    offset = v.off; length = v.len;
    k = 0; seen = 0;
    while (k < 5000 && !seen) begin
      @(negedge clk);
      k++;
      start = poke && (k == 20);
      legacy = poke ? !v.legacy : v.legacy;
      length = poke ? 8'd3 : v.len;
      seen = done;
    end
    start = 0;
    chk(seen, tag, "done seen", seen, 1);
    mism = 0; first = -1;
    for (int i = 0; i < exp_n && i < tn; i++)
      if (trace[i] !== expv[i]) begin mism++; if (first < 0) first = i; end
    chk(tn == exp_n, {tag, " R2"}, "command count", tn, exp_n);
    chk(mism == 0, {tag, " R2"}, "command mismatch at index", first,
        (first >= 0) ? int'(expv[first]) : -1);
    chk(error == exp_err, tag, "error flag", error, exp_err);
    if (v.rd) begin
      chk(rn == (exp_err ? 0 : int'(v.len)), {tag, " R5"}, "read bytes", rn,
          exp_err ? 0 : int'(v.len));
      for (int i = 0; i < rn && !exp_err; i++)
        chk(rdat[i] == rd_base + 8'(i), {tag, " R5"}, "read data", rdat[i], rd_base + 8'(i));
    end else
      chk(widx == exp_wcnt, {tag, " R6"}, "write bytes taken", widx, exp_wcnt);
    @(negedge clk);
    chk(!done && !busy, "R11", "done single pulse", done, 0);
    chk(error == exp_err, "R11", "error held", error, exp_err);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    int gap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error && !eng_req && !wr_ready && !rd_valid, "R1",
        "reset outputs", {busy, done, error, eng_req, wr_ready, rd_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      run(v, i, 1'b0,
          v.nack_at != 8'hFF ? "R9" : v.legacy ? "R3" : v.rd ? "R4" : v.pn != 0 ? "R7" : "R6");
      if (i == 0) begin
        gap = t_acc[2] - t_done[1];
        chk(gap >= GAP, "R4", "gap before repeated START", gap, GAP);
      end
    end

    // R1: start while busy ignored
    run(VECS[2], 2, 1'b1, "R1");

    // R8: poll timeout
    v = '{1'b0, 1'b0, 8'hA0, 8'h00, 8'd1, 8'd200, 8'hFF};
    run(v, 9, 1'b0, "R8");

    // R10: zero length
    @(negedge clk);
    tn = 0; cfg_nack_at = -1;
    start = 1; length = 0; rd = 1;
    @(negedge clk);
    start = 0;
    chk(done && !error, "R10", "zero length done", {done, error}, 2);
    repeat (4) @(negedge clk);
    chk(tn == 0, "R10", "no engine command", tn, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule